// File: doc/BRIEF.md
# Instruction Fetch Sequencer

This block drives the instruction side of a small 8-bit processor with a 14-bit address space. It reads an opcode byte from external memory, works out from the opcode's fields whether one or two more bytes follow (an immediate operand, or the low and high halves of a branch target), fetches them, and runs one memory-read, memory-write or I/O command cycle when the opcode needs one. It then presents the assembled instruction (opcode, operand byte, 14-bit target) for a single cycle. Execution of ALU and I/O instructions is left to the block's neighbours.

Every external transfer is a bus cycle that advertises a 2-bit cycle type and an address, and raises `wait_o` until the memory answers with `rdy_i`. The sequencer owns the program counter. It steps the counter after each fetched byte and evaluates jump, call and restart decisions against the incoming flags. An executing unit can also force a new program counter (for example on a return) during the issue cycle.

Top module: `insn_fetch_seq`

## Requirements
- R1: After synchronous reset the program counter is 0, `insn_valid_o` is low, and an opcode fetch (cycle type 00) to address 0 is pending with `wait_o` high.
- R2: `wait_o` is high while a bus cycle is pending. While `rdy_i` is low, the cycle type and address stay unchanged. The transfer completes, and `data_i` is taken, at the clock edge where `wait_o` and `rdy_i` are both high.
- R3: Cycle type codes are: 00 for the opcode fetch, 10 for operand bytes and memory reads, 11 for memory writes, and 01 for an I/O command.
- R4: Instruction length comes from the opcode. Forms 01 xxx xx0 take three bytes. Forms 00 xxx 100 and 00 xxx 110 take two bytes. Every other opcode takes one byte.
- R5: Opcode and operand bytes are fetched from the program counter. The counter steps by one, modulo 2^14, after each of these bytes and holds still at all other times.
- R6: One cycle after the last bus cycle, `insn_valid_o` is high for exactly one cycle. In that cycle the block shows the opcode, the operand byte (the second byte of two-byte forms, the read data of read cycles, otherwise 0) and the target `{high[5:0], low}` of three-byte forms (otherwise 0). Bits 7:6 of the high byte are ignored.
- R7: For 01 ccc 000 and 01 ccc 010, bit 5 is the required flag value and bits 4:3 select the flag in `flags_i` (bit 0 carry, 1 zero, 2 sign, 3 parity). Forms 01 xxx 100 and 01 xxx 110 are always taken. A taken transfer raises `branch_o` in the issue cycle, and the program counter loads the target only after both address bytes have arrived.
- R8: A restart 00 AAA 101 is a single byte. It is always taken, and its target is AAA shifted left by 3.
- R9: 10 xxx 111, and 11 xxx 111, cause a read cycle at `hl_i`. 11 111 sss with sss not 111, and 00 111 110 (after its operand byte), cause a write cycle at `hl_i`. `hl_i` is sampled when the last instruction byte completes.
- R10: An opcode 01 xxx xx1 is a single byte followed by an I/O command cycle whose address is the opcode's bits 5:1, zero-extended.
- R11: `redir_i` in the issue cycle loads the program counter from `redir_pc_i` and overrides a taken branch. At any other time it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rdy_i | input | 1 | Memory ready; completes the pending bus cycle |
| data_i | input | 8 | Byte returned by memory or I/O |
| flags_i | input | 4 | Condition flags: carry, zero, sign, parity (bit 0 to 3) |
| hl_i | input | 14 | Memory pointer for read and write cycles |
| redir_i | input | 1 | Program counter override request |
| redir_pc_i | input | 14 | Override value |
| wait_o | output | 1 | Bus cycle pending |
| cyc_type_o | output | 2 | Cycle type code |
| addr_o | output | 14 | Bus address |
| pc_o | output | 14 | Program counter |
| branch_o | output | 1 | Taken jump, call or restart in the issue cycle |
| insn_valid_o | output | 1 | Assembled instruction valid |
| insn_op_o | output | 8 | Opcode |
| insn_imm_o | output | 8 | Operand byte |
| insn_tgt_o | output | 14 | Branch target |

## Verification
The embedded properties check on every cycle that a stalled bus cycle keeps its type and address, and that the program counter either holds or steps by exactly one when no load occurs. They also check that the issue pulse lasts a single cycle and that `branch_o` only appears with it. Whether the right number of bytes is fetched, the correct cycle types and addresses are used, each flag and sense selects the right outcome, and the high byte's top bits are dropped can only be shown by the bench. It runs random opcodes with random ready delays and compares against its own model, alongside directed cases for restarts, writes, I/O commands, counter wrap and redirects outside the issue cycle.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int ADDR_W = 14;
    localparam int DATA_W = 8;
    localparam int HI_W   = ADDR_W - DATA_W;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'b00,
        CYC_CMD   = 2'b01,
        CYC_READ  = 2'b10,
        CYC_WRITE = 2'b11
    } cyc_t;

    typedef enum logic [2:0] {
        ST_OP, ST_LO, ST_HI, ST_MEM, ST_ISSUE
    } st_t;

    typedef struct packed {
        logic [1:0] nbytes;
        logic       has_mem;
        cyc_t       mem_kind;
        logic       is_xfer;
        logic       uncond;
        logic       is_rst;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] op;
        logic [DATA_W-1:0] imm;
        logic [ADDR_W-1:0] tgt;
    } insn_t;

    function automatic dec_t classify(input logic [DATA_W-1:0] op);
        dec_t d;
        d          = '0;
        d.nbytes   = 2'd1;
        d.mem_kind = CYC_READ;
        unique case (op[7:6])
            2'b00: begin
                if (op[2:0] == 3'b100) begin
                    d.nbytes = 2'd2;
                end else if (op[2:0] == 3'b110) begin
                    d.nbytes = 2'd2;
                    if (op[5:3] == 3'b111) begin
                        d.has_mem  = 1'b1;
                        d.mem_kind = CYC_WRITE;
                    end
                end else if (op[2:0] == 3'b101) begin
                    d.is_rst = 1'b1;
                end
            end
            2'b01: begin
                if (op[0]) begin
                    d.has_mem  = 1'b1;
                    d.mem_kind = CYC_CMD;
                end else begin
                    d.nbytes  = 2'd3;
                    d.is_xfer = 1'b1;
                    d.uncond  = op[2];
                end
            end
            2'b10: begin
                if (op[2:0] == 3'b111) d.has_mem = 1'b1;
            end
            default: begin
                if (op[2:0] == 3'b111) begin
                    d.has_mem = 1'b1;
                end else if (op[5:3] == 3'b111) begin
                    d.has_mem  = 1'b1;
                    d.mem_kind = CYC_WRITE;
                end
            end
        endcase
        return d;
    endfunction

    function automatic logic [ADDR_W-1:0] rst_vector(input logic [DATA_W-1:0] op);
        return ADDR_W'({op[5:3], 3'b000});
    endfunction

endpackage

// File: rtl/fseq_decode.sv
module fseq_decode
    import fseq_pkg::*;
(
    input  logic [DATA_W-1:0] op_i,
    output dec_t              dec_o
);
    always_comb begin
        dec_o = classify(op_i);
        a_len_r4: assert (dec_o.nbytes != 2'd0)
            else $error("decoded length zero");
    end
endmodule

// File: rtl/fseq_cond.sv
module fseq_cond
    import fseq_pkg::*;
(
    input  logic [DATA_W-1:0] op_i,
    input  dec_t              dec_i,
    input  logic [3:0]        flags_i,
    output logic              taken_o
);
    logic flag_sel;

    always_comb begin
        flag_sel = flags_i[op_i[4:3]];
        taken_o  = dec_i.is_rst
                 | (dec_i.is_xfer & (dec_i.uncond | (flag_sel == op_i[5])));
    end
endmodule

// File: rtl/fseq_pc.sv
module fseq_pc
    import fseq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc_i,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    output logic [AW-1:0] pc_o
);
    always_ff @(posedge clk) begin
        if (rst)         pc_o <= '0;
        else if (load_i) pc_o <= load_val_i;
        else if (inc_i)  pc_o <= pc_o + 1'b1;
    end

    p_pc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !inc_i) |=> $stable(pc_o));

    p_pc_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!load_i && inc_i) |=> (pc_o == AW'($past(pc_o) + 1'b1)));
endmodule

// File: rtl/insn_fetch_seq.sv
module insn_fetch_seq
    import fseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rdy_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [3:0]        flags_i,
    input  logic [ADDR_W-1:0] hl_i,
    input  logic              redir_i,
    input  logic [ADDR_W-1:0] redir_pc_i,
    output logic              wait_o,
    output logic [1:0]        cyc_type_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              branch_o,
    output logic              insn_valid_o,
    output logic [DATA_W-1:0] insn_op_o,
    output logic [DATA_W-1:0] insn_imm_o,
    output logic [ADDR_W-1:0] insn_tgt_o
);
    st_t               st_q;
    insn_t             rec_q;
    logic [ADDR_W-1:0] mem_addr_q;
    dec_t              dec_new, dec_cur;
    logic              hs, taken, pc_inc, pc_load;
    logic [ADDR_W-1:0] pc_val;
    st_t               after_op, after_lo;

    // Decode of the arriving opcode steers the first transition;
    // decode of the held opcode steers the rest.
    fseq_decode u_dec_new (.op_i(data_i),    .dec_o(dec_new));
    fseq_decode u_dec_cur (.op_i(rec_q.op),  .dec_o(dec_cur));

    fseq_cond u_cond (
        .op_i    (rec_q.op),
        .dec_i   (dec_cur),
        .flags_i (flags_i),
        .taken_o (taken)
    );

    assign wait_o = (st_q != ST_ISSUE);
    assign hs     = wait_o && rdy_i;

    always_comb begin
        after_op = (dec_new.nbytes != 2'd1) ? ST_LO
                 : (dec_new.has_mem ? ST_MEM : ST_ISSUE);
        after_lo = (dec_cur.nbytes == 2'd3) ? ST_HI
                 : (dec_cur.has_mem ? ST_MEM : ST_ISSUE);
    end

    // Last-byte flag: memory address captured on that edge (R9)
    logic mem_next;
    always_comb begin
        mem_next = 1'b0;
        if (hs && st_q == ST_OP && after_op == ST_MEM) mem_next = 1'b1;
        if (hs && st_q == ST_LO && after_lo == ST_MEM) mem_next = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_OP;
            rec_q      <= '0;
            mem_addr_q <= '0;
        end else begin
            if (mem_next) begin
                mem_addr_q <= hl_i;
            end
            unique case (st_q)
                ST_OP: if (hs) begin
                    rec_q.op  <= data_i;
                    rec_q.imm <= '0;
                    rec_q.tgt <= '0;
                    st_q      <= after_op;
                end
                ST_LO: if (hs) begin
                    if (dec_cur.nbytes == 2'd3) rec_q.tgt[DATA_W-1:0] <= data_i;
                    else                        rec_q.imm <= data_i;
                    st_q <= after_lo;
                end
                ST_HI: if (hs) begin
                    rec_q.tgt[ADDR_W-1:DATA_W] <= data_i[HI_W-1:0];
                    st_q <= ST_ISSUE;
                end
                ST_MEM: if (hs) begin
                    if (dec_cur.mem_kind == CYC_READ) rec_q.imm <= data_i;
                    st_q <= ST_ISSUE;
                end
                default: st_q <= ST_OP;
            endcase
        end
    end

    // Program counter control
    always_comb begin
        pc_inc  = hs && (st_q == ST_OP || st_q == ST_LO || st_q == ST_HI);
        pc_load = (st_q == ST_ISSUE) && (redir_i || taken);
        if (redir_i)             pc_val = redir_pc_i;
        else if (dec_cur.is_rst) pc_val = rst_vector(rec_q.op);
        else                     pc_val = rec_q.tgt;
    end

    fseq_pc #(.AW(ADDR_W)) u_pc (
        .clk        (clk),
        .rst        (rst),
        .inc_i      (pc_inc),
        .load_i     (pc_load),
        .load_val_i (pc_val),
        .pc_o       (pc_o)
    );

    // Bus presentation
    always_comb begin
        cyc_type_o = CYC_FETCH;
        addr_o     = pc_o;
        unique case (st_q)
            ST_OP:    cyc_type_o = CYC_FETCH;
            ST_LO,
            ST_HI:    cyc_type_o = CYC_READ;
            ST_MEM: begin
                cyc_type_o = dec_cur.mem_kind;
                addr_o     = (dec_cur.mem_kind == CYC_CMD)
                           ? ADDR_W'(rec_q.op[5:1]) : mem_addr_q;
            end
            default:  cyc_type_o = CYC_FETCH;
        endcase
    end

    // Instruction record
    always_comb begin
        insn_valid_o = (st_q == ST_ISSUE);
        branch_o     = insn_valid_o && taken;
        insn_op_o    = rec_q.op;
        insn_imm_o   = rec_q.imm;
        insn_tgt_o   = dec_cur.is_rst ? rst_vector(rec_q.op) : rec_q.tgt;
    end

    p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (wait_o && !rdy_i) |=> (wait_o && $stable(addr_o) && $stable(cyc_type_o)));

    p_issue_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        insn_valid_o |=> !insn_valid_o);

    p_branch_in_issue_r7: assert property (@(posedge clk) disable iff (rst)
        branch_o |-> insn_valid_o);

    p_fetch_after_issue_r5: assert property (@(posedge clk) disable iff (rst)
        insn_valid_o |=> (wait_o && cyc_type_o == 2'b00 && addr_o == pc_o));
endmodule

// File: tb/insn_fetch_seq_test.sv
`timescale 1ns/1ps
module insn_fetch_seq_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        rdy_i;
    logic [7:0]  data_i;
    logic [3:0]  flags_i;
    logic [13:0] hl_i;
    logic        redir_i;
    logic [13:0] redir_pc_i;
    logic        wait_o;
    logic [1:0]  cyc_type_o;
    logic [13:0] addr_o;
    logic [13:0] pc_o;
    logic        branch_o;
    logic        insn_valid_o;
    logic [7:0]  insn_op_o;
    logic [7:0]  insn_imm_o;
    logic [13:0] insn_tgt_o;

    int checks = 0;
    int fails  = 0;
    logic [13:0] mpc;

    insn_fetch_seq uut (
        .clk(clk), .rst(rst), .rdy_i(rdy_i), .data_i(data_i),
        .flags_i(flags_i), .hl_i(hl_i), .redir_i(redir_i),
        .redir_pc_i(redir_pc_i), .wait_o(wait_o), .cyc_type_o(cyc_type_o),
        .addr_o(addr_o), .pc_o(pc_o), .branch_o(branch_o),
        .insn_valid_o(insn_valid_o), .insn_op_o(insn_op_o),
        .insn_imm_o(insn_imm_o), .insn_tgt_o(insn_tgt_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model from the requirements
    function automatic int m_len(input logic [7:0] op);           // R4
        if (op[7:6] == 2'b01 && !op[0]) return 3;
        if (op[7:6] == 2'b00 && (op[2:0] == 3'b100 || op[2:0] == 3'b110)) return 2;
        return 1;
    endfunction

    function automatic logic [1:0] m_mem(input logic [7:0] op);   // R9/R10, 00 = none
        if (op[7:6] == 2'b01 && op[0]) return 2'b01;
        if (op == 8'h3E) return 2'b11;
        if (op[7] && op[2:0] == 3'b111) return 2'b10;
        if (op[7:6] == 2'b11 && op[5:3] == 3'b111) return 2'b11;
        return 2'b00;
    endfunction

    function automatic bit m_taken(input logic [7:0] op, input logic [3:0] fl);  // R7/R8
        if (op[7:6] == 2'b00 && op[2:0] == 3'b101) return 1'b1;
        if (op[7:6] != 2'b01 || op[0]) return 1'b0;
        if (op[2]) return 1'b1;
        return fl[op[4:3]] == op[5];
    endfunction

    task automatic bus_xfer(input logic [1:0] ty, input logic [13:0] ad,
                            input logic [7:0] d, input string req);
        int dly;
        dly = int'($urandom % 4);
        chk(wait_o === 1'b1, "R2", 32'(wait_o), 1);
        chk(cyc_type_o === ty, "R3", 32'(cyc_type_o), 32'(ty));
        chk(addr_o === ad, req, 32'(addr_o), 32'(ad));
        for (int i = 0; i < dly; i++) begin
            redir_i    = ($urandom % 2) == 0;        // R11: ignored outside issue
            redir_pc_i = 14'($urandom);
            @(negedge clk);
            chk(wait_o === 1'b1 && addr_o === ad && cyc_type_o === ty, "R2 R11 stall",
                32'(addr_o), 32'(ad));
        end
        redir_i = 1'b0;
        rdy_i   = 1'b1;
        data_i  = d;
        @(negedge clk);
        rdy_i   = 1'b0;
        data_i  = 8'($urandom);
    endtask

    task automatic run_insn(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2,
                            input logic [7:0] md, input logic [3:0] fl,
                            input bit rd, input logic [13:0] rpc);
        int          n;
        logic [1:0]  mk;
        bit          tk;
        logic [7:0]  eimm;
        logic [13:0] etgt, npc, hl;
        n  = m_len(op);
        mk = m_mem(op);
        tk = m_taken(op, fl);
        hl = 14'($urandom);
        flags_i = fl;
        hl_i    = hl;
        bus_xfer(2'b00, mpc, op, "R5 opcode addr");
        if (n >= 2) bus_xfer(2'b10, 14'(mpc + 14'd1), b1, "R5 operand addr");
        if (n == 3) bus_xfer(2'b10, 14'(mpc + 14'd2), b2, "R5 high addr");
        hl_i = 14'($urandom);                        // R9: sampled earlier
        if (mk != 2'b00)
            bus_xfer(mk, (mk == 2'b01) ? 14'(op[5:1]) : hl, md, "R9 R10 mem addr");
        eimm = (n == 2) ? b1 : (mk == 2'b10) ? md : 8'h00;
        etgt = (n == 3) ? {b2[5:0], b1}
             : (op[7:6] == 2'b00 && op[2:0] == 3'b101) ? {8'h00, op[5:3], 3'b000} : 14'h0;
        chk(insn_valid_o === 1'b1, "R6 valid", 32'(insn_valid_o), 1);
        chk(insn_op_o === op, "R6 op", 32'(insn_op_o), 32'(op));
        chk(insn_imm_o === eimm, "R6 imm", 32'(insn_imm_o), 32'(eimm));
        chk(insn_tgt_o === etgt, "R6 target", 32'(insn_tgt_o), 32'(etgt));
        chk(branch_o === tk, "R7 R8 branch", 32'(branch_o), 32'(tk));
        redir_i    = rd;
        redir_pc_i = rpc;
        npc = rd ? rpc : tk ? etgt : 14'(mpc + 14'(n));
        @(negedge clk);
        redir_i = 1'b0;
        chk(insn_valid_o === 1'b0, "R6 pulse", 32'(insn_valid_o), 0);
        chk(pc_o === npc, rd ? "R11 redirect" : "R7 R5 pc", 32'(pc_o), 32'(npc));
        mpc = npc;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; rdy_i = 1'b0; data_i = '0; flags_i = '0; hl_i = '0;
        redir_i = 1'b0; redir_pc_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(pc_o === 14'h0, "R1 pc", 32'(pc_o), 0);
        chk(insn_valid_o === 1'b0, "R1 valid", 32'(insn_valid_o), 0);
        chk(wait_o === 1'b1 && cyc_type_o === 2'b00 && addr_o === 14'h0, "R1 fetch",
            32'(addr_o), 0);
        mpc = 14'h0;

        // Directed corner cases
        run_insn(8'h68, 8'h77, 8'h00, 8'h00, 4'b0010, 1'b0, 14'h0);  // R7 jump if zero, taken
        run_insn(8'h68, 8'h12, 8'h00, 8'h00, 4'b0000, 1'b0, 14'h0);  // R7 not taken
        run_insn(8'h48, 8'h68, 8'h00, 8'h00, 4'b0000, 1'b0, 14'h0);  // R7 jump if not zero
        run_insn(8'h44, 8'hAB, 8'hFF, 8'h00, 4'b1111, 1'b0, 14'h0);  // R6 top bits of high byte dropped
        run_insn(8'h46, 8'h3C, 8'hC0, 8'h00, 4'b0000, 1'b0, 14'h0);  // R7 call
        run_insn(8'h3D, 8'h00, 8'h00, 8'h00, 4'b0000, 1'b0, 14'h0);  // R8 restart 7
        run_insn(8'h3C, 8'h2E, 8'h00, 8'h00, 4'b0000, 1'b0, 14'h0);  // R4 compare immediate
        run_insn(8'h3E, 8'h5A, 8'h00, 8'h00, 4'b0000, 1'b0, 14'h0);  // R9 load immediate to memory
        run_insn(8'hC7, 8'h00, 8'h00, 8'h9C, 4'b0000, 1'b0, 14'h0);  // R9 read
        run_insn(8'hF8, 8'h00, 8'h00, 8'h00, 4'b0000, 1'b0, 14'h0);  // R9 write
        run_insn(8'h53, 8'h00, 8'h00, 8'h11, 4'b0000, 1'b0, 14'h0);  // R10 I/O command
        run_insn(8'h07, 8'h00, 8'h00, 8'h00, 4'b0000, 1'b1, 14'h3FFE); // R11 redirect
        run_insn(8'h36, 8'hC8, 8'h00, 8'h00, 4'b0000, 1'b0, 14'h0);  // R5 wrap across 3FFF
        run_insn(8'h7C, 8'h10, 8'h20, 8'h00, 4'b0000, 1'b1, 14'h0100); // R11 beats taken jump

        // Constrained random
        for (int k = 0; k < 400; k++) begin
            logic [7:0] op;
            op = 8'($urandom);
            if (op == 8'hFF) op = 8'hC0;
            run_insn(op, 8'($urandom), 8'($urandom), 8'($urandom), 4'($urandom),
                     ($urandom % 8) == 0, 14'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule